// File: doc/BRIEF.md
# Joystick Axis Timing Unit

This block times four resistive joystick axes. Each axis is modelled by a comparator input that goes high when the external RC one-shot for that axis runs out. The host starts a measurement by writing the value register. Every enabled axis counter then clears to zero and advances on ticks of a selectable prescaler until its comparator trips. The count is a measure of the axis position.

The host sees an 8-bit wide register window with byte offsets. Through it the host enables axes, chooses which result appears at the 16-bit value port, picks the counter rate and enables an interrupt. A continuous mode restarts the measurement on its own after a programmable gap, which is about 16 ms at the default setting. Four button lines can be read as plain status. A ready flag and a level interrupt report completion.

Top module: `joy_axis_timer`

## Requirements
- R1: Offset 0x01 holds the axis configuration. Bits 3:0 enable axes 1 to 4. A measurement changes only the enabled axes, and a disabled axis keeps its previous value.
- R2: Bits 5:4 of offset 0x01 pick the axis shown when offset 0x02 is read: 00 gives axis 1, 01 axis 2, 10 axis 3 and 11 axis 4.
- R3: Offset 0x04 holds the hardware configuration. Bit 0 is the interrupt enable, bits 2:1 set the rate and bit 3 drives `legacy_en`. On read, bits 15:4 are zero.
- R4: A write of any value to offset 0x02 clears every enabled counter to zero. Each of those counters then adds one per prescaler tick until its comparator input is sampled high.
- R5: A counter that reaches 0xFFFF stops there and does not wrap.
- R6: Rate code 00 ticks every clock, 10 every 2 clocks, 01 every 20 clocks and 11 every 200 clocks. A comparator that rises d clocks after the start gives floor(d/divisor).
- R7: The ready flag appears as bit 7 of offset 0x01 and on the `ready` port. It is cleared by a start. It sets once every enabled axis has stopped counting.
- R8: `irq` is a level output. It sets on completion of a measurement when interrupts are enabled. A write to 0x02 or a read of 0x01 clears it.
- R9: A write to offset 0x00 sets `irq` only when interrupts are enabled and at least one axis is enabled. In any other case it has no effect.
- R10: Bit 6 of offset 0x01 selects continuous mode. In this mode a new measurement starts LATCH_GAP clocks after the previous start, and each completion raises the interrupt. With the bit clear, no new measurement starts and the stored values stay frozen.
- R11: A read of offset 0x00 returns the four button inputs in bits 3:0, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data for the current offset |
| cmp_in | input | 4 | Axis comparator inputs, high when tripped |
| btn_in | input | 4 | Button status inputs |
| ready | output | 1 | Measurement complete |
| irq | output | 1 | Level interrupt |
| legacy_en | output | 1 | Legacy address window enable |

## Verification
The assertions take three things for granted. A comparator input only rises during a measurement and then stays high until the next start. The host does not rewrite the rate code while a tick is pending. A read of 0x01 and a write to 0x00 never fall in the same cycle as a completion. The stimulus drops every comparator to low before each start and changes the configuration only between measurements. It raises each comparator once, at a chosen clock after the write, and issues register accesses only after `ready` has settled.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int N_AXES = 4;
  localparam int SEL_W  = $clog2(N_AXES);
  localparam int DIV_W  = 8;

  localparam logic [2:0] OFS_TRIG = 3'd0;
  localparam logic [2:0] OFS_CFG  = 3'd1;
  localparam logic [2:0] OFS_VAL  = 3'd2;
  localparam logic [2:0] OFS_HW   = 3'd4;

  // rate code -> clocks per counter tick
  function automatic logic [DIV_W-1:0] rate_div(input logic [1:0] code);
    case (code)
      2'b00:   rate_div = 8'd1;
      2'b10:   rate_div = 8'd2;
      2'b01:   rate_div = 8'd20;
      default: rate_div = 8'd200;
    endcase
  endfunction
endpackage

// File: rtl/joy_prescaler.sv
module joy_prescaler import joy_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] div;

  assign div  = rate_div(rate);
  assign tick = (pc >= div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (restart) pc <= '0;
    else if (tick)    pc <= '0;
    else              pc <= pc + 1'b1;
  end

  // R6: above full rate, two ticks never fall in back-to-back cycles
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != 2'b00 && !restart) |=> (!tick || rate == 2'b00));
endmodule

// File: rtl/joy_axis_ctr.sv
module joy_axis_ctr #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic             tick,
  input  logic             cmp,
  output logic [VAL_W-1:0] value,
  output logic             running
);
  localparam logic [VAL_W-1:0] VMAX = '1;

  logic at_max;
  assign at_max = (value == VMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      running <= 1'b0;
    end else if (start) begin
      if (enable) begin
        value   <= '0;
        running <= 1'b1;
      end
    end else if (running) begin
      if (cmp)
        running <= 1'b0;
      else if (tick) begin
        if (at_max) running <= 1'b0;
        else        value <= value + 1'b1;
      end
    end
  end

  // R4: an enabled axis restarts from zero
  a_r4_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enable) |=> (value == '0));
  // R5: a saturated count never wraps
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !start) |=> at_max);
endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer import joy_pkg::*; #(
  parameter int VAL_W     = 16,
  parameter int LATCH_GAP = 3_200_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [VAL_W-1:0] rdata,
  input  logic [3:0]       cmp_in,
  input  logic [3:0]       btn_in,
  output logic             ready,
  output logic             irq,
  output logic             legacy_en
);
  localparam int GAP_W = $clog2(LATCH_GAP + 1);

  logic [N_AXES-1:0] ax_en;
  logic [SEL_W-1:0]  sel;
  logic              cont_en;
  logic              irq_en;
  logic [1:0]        rate;
  logic [GAP_W-1:0]  gap_cnt;
  logic              meas_active;

  logic wr_trig, wr_cfg, wr_val, wr_hw, rd_cfg;
  logic auto_start, start, tick, any_run, done_evt, trig_irq;
  logic [N_AXES-1:0] run;
  logic [VAL_W-1:0]  val [N_AXES];

  assign wr_trig = wr_en && addr == OFS_TRIG;
  assign wr_cfg  = wr_en && addr == OFS_CFG;
  assign wr_val  = wr_en && addr == OFS_VAL;
  assign wr_hw   = wr_en && addr == OFS_HW;
  assign rd_cfg  = rd_en && addr == OFS_CFG;

  assign auto_start = cont_en && (gap_cnt == GAP_W'(LATCH_GAP - 1));
  assign start      = wr_val || auto_start;
  assign any_run    = |run;
  assign done_evt   = meas_active && !any_run && !start;
  assign trig_irq   = wr_trig && (|ax_en) && irq_en;

  joy_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start), .rate(rate), .tick(tick)
  );

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    joy_axis_ctr #(.VAL_W(VAL_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(ax_en[g]),
      .tick(tick), .cmp(cmp_in[g]), .value(val[g]), .running(run[g])
    );
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_en     <= '0;
      sel       <= '0;
      cont_en   <= 1'b0;
      irq_en    <= 1'b0;
      rate      <= 2'b00;
      legacy_en <= 1'b0;
    end else begin
      if (wr_cfg) begin
        ax_en   <= wdata[3:0];
        sel     <= wdata[5:4];
        cont_en <= wdata[6];
      end
      if (wr_hw) begin
        irq_en    <= wdata[0];
        rate      <= wdata[2:1];
        legacy_en <= wdata[3];
      end
    end
  end

  // continuous-mode restart interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_cnt <= '0;
    else if (!cont_en || start) gap_cnt <= '0;
    else                        gap_cnt <= gap_cnt + 1'b1;
  end

  // completion tracking, ready flag and interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_active <= 1'b0;
      ready       <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (start) begin
        meas_active <= 1'b1;
        ready       <= 1'b0;
      end else if (done_evt) begin
        meas_active <= 1'b0;
        ready       <= 1'b1;
      end
      if ((done_evt && irq_en) || trig_irq) irq <= 1'b1;
      else if (wr_val || rd_cfg)            irq <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_TRIG: rdata[3:0] = btn_in;
      OFS_CFG:  rdata[7:0] = {ready, cont_en, sel, ax_en};
      OFS_VAL:  rdata      = val[sel];
      OFS_HW:   rdata[3:0] = {legacy_en, rate, irq_en};
      default:  rdata      = '0;
    endcase
  end

  // R7: ready never shows while a counter still runs
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !any_run);
  // R7: a start drops ready
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  // R8: a value write leaves irq low
  a_r8_val_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> !irq);
endmodule

// File: tb/sim_joy_axis_timer.sv
module sim_joy_axis_timer;
  localparam int GAP = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0] cmp_in = '0, btn_in = '0;
  logic ready, irq, legacy_en;

  int n_chk = 0, n_bad = 0;
  int model [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  joy_axis_timer #(.VAL_W(16), .LATCH_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_in(cmp_in), .btn_in(btn_in),
    .ready(ready), .irq(irq), .legacy_en(legacy_en)
  );

  function automatic int expect_count(input int d, input logic [1:0] code);
    int r;
    if (code == 2'b00)      r = d;
    else if (code == 2'b10) r = d / 2;
    else if (code == 2'b01) r = d / 20;
    else                    r = d / 200;
    if (r > 65535) r = 65535;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_cfg();
    rd_en = 1'b1; addr = 3'd1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    addr = a; #1; v = rdata;
  endtask

  task automatic read_axis(input int ax, input logic [7:0] cfg_low, output int v);
    wr(3'd1, cfg_low | 8'(ax << 4));
    peek(3'd2, v);
  endtask

  task automatic measure(input logic [3:0] mask, input logic [1:0] code,
                         input int d0, input int d1, input int d2, input int d3);
    int d [4];
    int mx, v;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    mx = 0;
    for (int i = 0; i < 4; i++) if (d[i] > mx) mx = d[i];
    wr(3'd4, {5'b0, code, 1'b1});
    wr(3'd1, {4'b0, mask});
    cmp_in = '0;
    wr(3'd2, 8'h00);
    check("R7 ready cleared by start", ready, 0);
    check("R8 irq cleared by value write", irq, 0);
    for (int t = 0; t <= mx; t++) begin
      for (int i = 0; i < 4; i++) if (d[i] == t) cmp_in[i] = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 ready after all stop", ready, 1);
    check("R8 irq on completion", irq, 1);
    for (int i = 0; i < 4; i++) if (mask[i]) model[i] = expect_count(d[i], code);
    for (int i = 0; i < 4; i++) begin
      read_axis(i, {4'b0, mask}, v);
      check(mask[i] ? "R4 R6 axis count" : "R1 disabled axis kept", v, model[i]);
    end
    cmp_in = '0;
  endtask

  initial begin
    int v, seed;
    logic [3:0] m;
    seed = $urandom(32'd20240);
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (4) @(negedge clk);
    check("R7 ready reset", ready, 0);
    check("R8 irq reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 buttons
    btn_in = 4'b1010; peek(3'd0, v);
    check("R11 buttons", v, 16'h000A);
    // R3 hardware config readback
    wr(3'd4, 8'hFF); peek(3'd4, v);
    check("R3 hw cfg upper zero", v, 16'h000F);
    check("R3 legacy_en", legacy_en, 1);
    wr(3'd4, 8'h01);
    check("R3 legacy_en off", legacy_en, 0);
    // R1 R2 config readback
    wr(3'd1, 8'h35); peek(3'd1, v);
    check("R1 R2 cfg readback", v & 8'h7F, 8'h35);

    // R9 trigger write
    wr(3'd1, 8'h00); wr(3'd0, 8'h5A);
    check("R9 no irq without axes", irq, 0);
    wr(3'd1, 8'h02); wr(3'd0, 8'h00);
    check("R9 irq with axis and enable", irq, 1);
    rd_cfg();
    check("R8 irq cleared by cfg read", irq, 0);

    // directed rate cases
    measure(4'hF, 2'b00, 0, 5, 17, 40);
    measure(4'hF, 2'b10, 1, 6, 33, 7);
    measure(4'h5, 2'b01, 19, 300, 60, 2);
    measure(4'hA, 2'b11, 500, 199, 3, 401);

    // random patterns
    for (int n = 0; n < 16; n++) begin
      m = 4'($urandom_range(1, 15));
      measure(m, 2'($urandom_range(0, 3)), $urandom_range(0, 600),
              $urandom_range(0, 600), $urandom_range(0, 600), $urandom_range(0, 600));
    end

    // R5 saturation
    wr(3'd4, 8'h01); wr(3'd1, 8'h01); cmp_in = '0;
    wr(3'd2, 8'h00);
    repeat (66000) @(negedge clk);
    peek(3'd2, v);
    check("R5 saturates", v, 16'hFFFF);
    check("R5 ready after saturation", ready, 1);
    cmp_in = 4'hF; @(negedge clk); cmp_in = '0;

    // R10 continuous mode
    wr(3'd1, 8'h41); wr(3'd2, 8'h00);
    repeat (500) @(negedge clk);
    peek(3'd2, v);
    check("R4 live count", v, 500);
    cmp_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd_cfg();
    check("R8 irq cleared", irq, 0);
    repeat (3000) @(negedge clk);
    peek(3'd2, v);
    check("R10 auto restart value", v, 0);
    check("R10 auto restart irq", irq, 1);
    wr(3'd1, 8'h01); rd_cfg(); cmp_in = '0;
    repeat (4000) @(negedge clk);
    peek(3'd2, v);
    check("R10 frozen when off", v, 0);
    check("R10 no irq when off", irq, 0);
    check("R10 ready stays", ready, 1);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule